// File: doc/BRIEF.md
# SMBus Event Interrupt and SMI Steering Unit

This unit gathers the event sources of an SMBus host controller and steers each of them to one or more of three outputs: a general interrupt line, a host SMI line and a slave SMI line. There are three kinds of source. The first is an active-low alert pin, which is synchronized and edge-detected. The second is four host status events: transaction failed, bus collision, device error and transaction done. The third is a host-notify event. Each source sets a sticky status bit. The outputs are registered functions of those status bits and a small set of software enable bits.

A single SMI-select control moves the events between the interrupt path and the SMI paths. When SMI-select is set, host events go to the host SMI line, and alert and notify events go to the slave SMI line. The routing conditions are additive. When several are true at once, every output they name is asserted together. Software reads the status bits and clears them by writing ones.

Top module: `smb_evt_router`

## Requirements
- R1: A high-to-low transition of `alert_n_i`, after a two-flop synchronizer, sets status bit 4 whatever the enables are. Holding the pin low does not set the bit again after it has been cleared.
- R2: With SMI-select (control bit 1) at 1 and alert-disable (control bit 2) at 0, a set alert status raises `slave_smi_o` and sets the slave-SMI status flag (status bit 6). This holds whatever the interrupt enable is.
- R3: With interrupt enable (control bit 0) at 1, SMI-select at 0 and alert-disable at 0, a set alert status raises `irq_o`. With alert-disable at 1, alert status raises no output.
- R4: `host_evt_i[i]` sets status bit i (0 failed, 1 collision, 2 device error, 3 done). With interrupt enable at 0, these bits raise no output at either SMI-select value.
- R5: With interrupt enable at 1, any set host status bit raises `irq_o` when SMI-select is 0 and `host_smi_o` when SMI-select is 1.
- R6: `notify_i` sets status bit 5. With notify-interrupt enable (control bit 3) at 1, this bit raises `irq_o` when SMI-select is 0. When SMI-select is 1, it raises `slave_smi_o` and sets status bit 6.
- R7: With notify-interrupt enable at 0, a set notify status raises no output, whatever the notify-wake enable (control bit 4) is.
- R8: Routing is additive. Every output whose condition holds is asserted at the same time.
- R9: Writing 1 to a status bit at address 1 clears it, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins. Outputs fall once their contributing bits are cleared.
- R10: Address 0 reads and writes the five control bits, and address 1 reads the status. Other addresses read as 0. An output reflects a control write on the clock after the write is captured.
- R11: After reset all outputs, control bits and status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alert_n_i | input | 1 | Asynchronous active-low alert pin |
| host_evt_i | input | 4 | Host status event strobes (failed, collision, device error, done) |
| notify_i | input | 1 | Host-notify event strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |
| host_smi_o | output | 1 | Host SMI request |
| slave_smi_o | output | 1 | Slave SMI request |

## Verification
The hardest case to reach is a clear that collides with a live routing condition. Suppose software clears the slave-SMI flag together with the alert bit while SMI-select still routes the alert. The flag is then re-set in that same cycle. Reaching this needs an alert edge, the right control value and a combined write-one-to-clear, in that order. The stimulus reaches it with a directed sequence, and random interleaving of control writes, clears, pin toggles and event strobes revisits it. A bench model applies each operation to its own copy of the status and replays the set-wins rule.

// File: rtl/smb_evt_pkg.sv
package smb_evt_pkg;
   localparam int unsigned HOST_W    = 4;
   localparam int unsigned CTRL_BITS = 5;
   localparam int unsigned STAT_BITS = 7;

   localparam int unsigned SB_ALERT  = 4;
   localparam int unsigned SB_NTF    = 5;
   localparam int unsigned SB_SLV    = 6;

   typedef struct packed {
      logic ntf_wake;
      logic ntf_irq;
      logic alert_dis;
      logic smi_sel;
      logic irq_en;
   } ctrl_t;

   typedef struct packed {
      logic irq;
      logic host_smi;
      logic slave_smi;
   } route_t;
endpackage

// File: rtl/smb_alert_sync.sv
module smb_alert_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   output logic fall_o
);
   localparam int unsigned TOP = STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smb_alert_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
      end else begin
         shreg_q <= {shreg_q[TOP-1:0], pin_n_i};
      end
   end

   assign fall_o = shreg_q[TOP] & ~shreg_q[TOP-1];
endmodule

// File: rtl/smb_sticky_bank.sv
module smb_sticky_bank #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("smb_sticky_bank: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= 1'b0;
            end else begin
               q <= set_i[i] | (q & ~clr_i[i]);
            end
         end
         assign q_o[i] = q;
      end
   endgenerate
endmodule

// File: rtl/smb_route_logic.sv
module smb_route_logic
   import smb_evt_pkg::*;
#(
   parameter int unsigned NHOST = HOST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctrl_t            ctrl_i,
   input  logic [NHOST-1:0] host_sts_i,
   input  logic             alert_sts_i,
   input  logic             ntf_sts_i,
   output logic             slv_set_o,
   output logic             irq_o,
   output logic             host_smi_o,
   output logic             slave_smi_o
);
   logic   host_any;
   logic   alert_live;
   logic   ntf_live;
   route_t nxt;
   route_t cur_q;

   assign host_any   = |host_sts_i;
   assign alert_live = alert_sts_i & ~ctrl_i.alert_dis;
   assign ntf_live   = ntf_sts_i & ctrl_i.ntf_irq;

   always_comb begin
      nxt = '0;
      if (ctrl_i.smi_sel) begin
         nxt.host_smi  = ctrl_i.irq_en & host_any;
         nxt.slave_smi = alert_live | ntf_live;
      end else begin
         nxt.irq = (ctrl_i.irq_en & host_any)
                 | (ctrl_i.irq_en & alert_live)
                 | ntf_live;
      end
   end

   assign slv_set_o = nxt.slave_smi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else begin
         cur_q <= nxt;
      end
   end

   assign irq_o       = cur_q.irq;
   assign host_smi_o  = cur_q.host_smi;
   assign slave_smi_o = cur_q.slave_smi;
endmodule

// File: rtl/smb_evt_router.sv
module smb_evt_router
   import smb_evt_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alert_n_i,
   input  logic [HOST_W-1:0] host_evt_i,
   input  logic              notify_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o,
   output logic              host_smi_o,
   output logic              slave_smi_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = '0;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

   generate
      if (DATA_W < STAT_BITS) begin : g_bad_data_w
         $error("smb_evt_router: DATA_W too narrow for status");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("smb_evt_router: ADDR_W must be positive");
      end
   endgenerate

   ctrl_t                ctrl_q;
   logic [STAT_BITS-1:0] sts_q;
   logic [STAT_BITS-1:0] sts_set;
   logic [STAT_BITS-1:0] sts_clr;
   logic                 alert_fall;
   logic                 slv_set;
   logic                 wr_ctrl;
   logic                 wr_stat;
   logic                 unused_wdata;

   assign wr_ctrl = reg_wr_i & (reg_addr_i == A_CTRL);
   assign wr_stat = reg_wr_i & (reg_addr_i == A_STAT);
   assign unused_wdata = ^reg_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_BITS-1:0]);
      end
   end

   smb_alert_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n_i (alert_n_i),
      .fall_o  (alert_fall)
   );

   assign sts_set = {slv_set, notify_i, alert_fall, host_evt_i};
   assign sts_clr = wr_stat ? reg_wdata_i[STAT_BITS-1:0] : '0;

   smb_sticky_bank #(
      .N (STAT_BITS)
   ) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sts_set),
      .clr_i (sts_clr),
      .q_o   (sts_q)
   );

   smb_route_logic #(
      .NHOST (HOST_W)
   ) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_i      (ctrl_q),
      .host_sts_i  (sts_q[HOST_W-1:0]),
      .alert_sts_i (sts_q[SB_ALERT]),
      .ntf_sts_i   (sts_q[SB_NTF]),
      .slv_set_o   (slv_set),
      .irq_o       (irq_o),
      .host_smi_o  (host_smi_o),
      .slave_smi_o (slave_smi_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == A_CTRL) begin
         reg_rdata_o = DATA_W'(ctrl_q);
      end else if (reg_addr_i == A_STAT) begin
         reg_rdata_o = DATA_W'(sts_q);
      end
   end
endmodule

// File: rtl/smb_evt_router_chk.sv
module smb_evt_router_chk
   import smb_evt_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input ctrl_t                ctrl,
   input logic [STAT_BITS-1:0] sts,
   input logic [STAT_BITS-1:0] clr,
   input logic [HOST_W-1:0]    hevt,
   input logic                 irq,
   input logic                 hsmi,
   input logic                 ssmi
);
   p_host_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.irq_en && !ctrl.smi_sel && (|sts[HOST_W-1:0])) |=> irq);

   p_host_smi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.irq_en && ctrl.smi_sel && (|sts[HOST_W-1:0])) |=> hsmi);

   p_host_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.irq_en |=> !hsmi);

   p_sel_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.smi_sel |=> !irq);

   p_sel_smi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.smi_sel |=> (!hsmi && !ssmi));

   p_slave_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ssmi |-> sts[SB_SLV]);

   p_alert_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[SB_ALERT] && !clr[SB_ALERT]) |=> sts[SB_ALERT]);

   p_host_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hevt[0] |=> sts[0]);
endmodule

bind smb_evt_router smb_evt_router_chk u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .ctrl (ctrl_q),
   .sts  (sts_q),
   .clr  (sts_clr),
   .hevt (host_evt_i),
   .irq  (irq_o),
   .hsmi (host_smi_o),
   .ssmi (slave_smi_o)
);

// File: tb/test_smb_evt_router.sv
`timescale 1ns/1ps
module test_smb_evt_router;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alert_n = 1'b1;
   logic [3:0] host_evt = '0;
   logic       notify = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq, hsmi, ssmi;

   int n_cmp = 0;
   int n_bad = 0;
   logic [4:0] m_ctrl = '0;
   logic [6:0] m_sts = '0;

   always #2 clk = ~clk;

   smb_evt_router i_smb_evt_router (
      .clk(clk), .rst_n(rst_n), .alert_n_i(alert_n), .host_evt_i(host_evt),
      .notify_i(notify), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .irq_o(irq), .host_smi_o(hsmi), .slave_smi_o(ssmi));

   function automatic logic f_slv(logic [4:0] c, logic [6:0] s);
      return c[1] & ((s[4] & ~c[2]) | (s[5] & c[3]));
   endfunction
   function automatic logic f_irq(logic [4:0] c, logic [6:0] s);
      return ~c[1] & ((c[0] & |s[3:0]) | (c[0] & ~c[2] & s[4]) | (c[3] & s[5]));
   endfunction
   function automatic logic f_hsmi(logic [4:0] c, logic [6:0] s);
      return c[1] & c[0] & |s[3:0];
   endfunction

   task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic settle();
      if (f_slv(m_ctrl, m_sts)) m_sts[6] = 1'b1;
      idle(4);
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic check_all(string req);
      logic [7:0] d;
      chk(req, "irq", {7'd0, irq}, {7'd0, f_irq(m_ctrl, m_sts)});
      chk(req, "host_smi", {7'd0, hsmi}, {7'd0, f_hsmi(m_ctrl, m_sts)});
      chk(req, "slave_smi", {7'd0, ssmi}, {7'd0, f_slv(m_ctrl, m_sts)});
      rd(2'd1, d);
      chk(req, "status", d, {1'b0, m_sts});
      rd(2'd0, d);
      chk(req, "control", d, {3'd0, m_ctrl});
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic op_ctrl(logic [4:0] v);
      wr(2'd0, {3'd0, v});
      m_ctrl = v;
      settle();
   endtask

   task automatic op_clear(logic [6:0] v);
      logic cond;
      cond = f_slv(m_ctrl, m_sts);
      wr(2'd1, {1'b0, v});
      m_sts = m_sts & ~v;
      if (cond) m_sts[6] = 1'b1;
      settle();
   endtask

   task automatic op_host(logic [3:0] v);
      @(negedge clk); host_evt = v;
      @(negedge clk); host_evt = '0;
      m_sts[3:0] = m_sts[3:0] | v;
      settle();
   endtask

   task automatic op_notify();
      @(negedge clk); notify = 1'b1;
      @(negedge clk); notify = 1'b0;
      m_sts[5] = 1'b1;
      settle();
   endtask

   task automatic op_alert();
      @(negedge clk); alert_n = 1'b0;
      idle(4);
      alert_n = 1'b1;
      m_sts[4] = 1'b1;
      settle();
   endtask

   initial begin : watchdog
      #(4.0 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      void'($urandom(32'h5EED_1234));
      idle(3);
      // R11 reset state
      chk("R11", "irq", {7'd0, irq}, 8'd0);
      chk("R11", "host_smi", {7'd0, hsmi}, 8'd0);
      chk("R11", "slave_smi", {7'd0, ssmi}, 8'd0);
      rst_n = 1'b1;
      idle(2);
      check_all("R11");
      rd(2'd2, d);
      chk("R10", "unmapped read", d, 8'd0);

      // R4 host events gated by interrupt enable
      op_host(4'hF);
      check_all("R4");
      op_ctrl(5'b00010);
      check_all("R4");

      // R10 control write timing, R5 routing
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
      @(negedge clk);
      reg_wr = 1'b0;
      m_ctrl = 5'b00001;
      chk("R10", "irq same clock as write", {7'd0, irq}, 8'd0);
      @(negedge clk);
      chk("R10", "irq clock after write", {7'd0, irq}, 8'd1);
      settle();
      check_all("R5");
      op_ctrl(5'b00011);
      check_all("R5");

      // R9 clears, zero writes, set wins
      op_clear(7'h0F);
      check_all("R9");
      op_host(4'h1);
      op_clear(7'h00);
      check_all("R9");
      @(negedge clk);
      host_evt = 4'h1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
      @(negedge clk);
      host_evt = '0; reg_wr = 1'b0;
      settle();
      check_all("R9");
      op_clear(7'h7F);

      // R1 alert with everything off; held low does not re-arm
      op_ctrl(5'b00000);
      op_alert();
      check_all("R1");
      @(negedge clk); alert_n = 1'b0;
      idle(5);
      m_sts[4] = 1'b1;
      op_clear(7'h10);
      idle(4);
      check_all("R1");
      @(negedge clk); alert_n = 1'b1;
      idle(4);
      op_alert();

      // R3 alert to interrupt, alert-disable blocks it
      op_ctrl(5'b00001);
      check_all("R3");
      op_ctrl(5'b00101);
      check_all("R3");

      // R2 alert to slave SMI with interrupt enable off; flag re-set on collision
      op_ctrl(5'b00010);
      check_all("R2");
      op_clear(7'h50);
      check_all("R2");
      op_clear(7'h40);
      check_all("R2");

      // R6 notify routing
      op_ctrl(5'b01000);
      op_notify();
      check_all("R6");
      op_ctrl(5'b01010);
      check_all("R6");
      op_clear(7'h7F);
      op_clear(7'h40);

      // R7 wake enable alone routes nothing
      op_ctrl(5'b10000);
      op_notify();
      check_all("R7");
      op_ctrl(5'b10010);
      check_all("R7");

      // R8 additive combinations
      op_ctrl(5'b01001);
      op_host(4'h4);
      op_alert();
      check_all("R8");
      op_ctrl(5'b01011);
      check_all("R8");

      for (int k = 0; k < 300; k++) begin
         case ($urandom_range(0, 4))
            0: op_host(4'($urandom));
            1: op_notify();
            2: op_alert();
            3: op_ctrl(5'($urandom));
            default: op_clear(7'($urandom));
         endcase
         check_all("R8");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule